// File: doc/BRIEF.md
# Serial Flash Read-Command Responder

This block plays the memory side of a four-wire serial flash link and answers only the read-bytes command. An external controller selects the block by pulling chip-select low, clocks in one command byte and then a 24-bit start address, and afterwards receives a stream of bytes from a small internal read-only array. The stream has no fixed length. After each byte the address advances by one and wraps to zero past the top. The read stops as soon as chip-select is released.

The serial clock, chip-select and data input are taken into the system clock domain through a synchroniser and an edge detector, so the serial clock must run well below the system clock (at least about four system cycles per serial half period). A control state machine handles all protocol decisions. Its states are IDLE (not selected), OPCODE (collecting the command byte), ADDR (collecting the address), DATA (streaming bytes) and IGNORE (waiting out a rejected command). Its transitions are:
- SELECT: IDLE to OPCODE, when chip-select is seen low.
- ACCEPT: OPCODE to ADDR, on the eighth command bit when it completes the read code and busy is low.
- REJECT: OPCODE to IGNORE, on the eighth command bit in every other case.
- STREAM: ADDR to DATA, on the 24th address bit.
- DESELECT: any state to IDLE, whenever chip-select is seen high.

The data output comes as a value and an enable, and the pad is driven only while the enable is high. A busy input marks a write or erase cycle in progress. A read command that completes while busy is high is dropped without any effect.

Top module: `spi_read_responder`

## Requirements
- R1: After reset, and at any time chip-select is high, `sdo_oe` is 0, whatever the serial clock does.
- R2: A transaction is accepted as a read when its first eight bits, sampled on rising serial clock edges and taken most significant bit first, equal 0x03. The next 24 bits form the start address, most significant bit first. The bytes that follow are array contents, sent most significant bit first. The array holds mem[i] = (i*29 + SEED) mod 256, with i = address mod DEPTH.
- R3: The output bit changes only after a falling serial clock edge and is held through the following high phase. The first data bit is presented after the falling edge that closes the 32nd command bit, and `sdo_oe` stays 1 throughout the data phase.
- R4: After each complete byte, the next byte comes from the address plus one, for as long as chip-select stays low.
- R5: The address wraps from 0xFFFFFF to 0x000000, and from the top of the array to index 0, without a gap in the stream.
- R6: Within four system clock cycles of chip-select going high, `sdo_oe` returns to 0. This holds wherever the transaction was cut off: in the command byte, in the address or in the middle of a data byte. The next transaction is decoded from its first bit.
- R7: If the read code completes while `busy` is 1, no data is driven (`sdo_oe` stays 0) until chip-select rises, even if `busy` falls later in the same transaction.
- R8: A first byte other than 0x03 makes the block ignore every remaining clock, with `sdo_oe` at 0 until chip-select rises. The next transaction works normally.
- R9: Address bits at or above log2(DEPTH) do not select data. For example, 0xABCD05 reads the same bytes as index 5.
- R10: `sdo_oe` stays 0 through the command and address phases of an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip-select from the controller, active low |
| sclk | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data in (command and address) |
| busy | input | 1 | High while a write or erase cycle is in progress |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Drive enable for the data-out pad; 0 means high impedance |

## Verification
The bench builds the block with DEPTH = 64 and SEED = 0x5B, and runs eight system cycles per serial half period. The 64-entry array puts the array-top wrap within reach of a few bytes' read. With random 24-bit start addresses, the upper address bits are regularly non-zero, so the modulo mapping is exercised as well. The start address 0xFFFFFE drives the full 24-bit counter across its own wrap. The half period of eight cycles leaves room past the synchroniser latency, so output stability can be sampled at both ends of each high phase.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_IGNORE
    } rsp_state_e;

    localparam logic [7:0] RD_OPCODE = 8'h03;
    localparam int         OPC_BITS  = 8;
    localparam int         ADDR_BITS = 24;
    localparam int         CNT_W     = $clog2(ADDR_BITS + 1);

endpackage

// File: rtl/rsp_sync.sv
module rsp_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= {STAGES{RST_VAL[g]}};
            end else begin
                pipe_q <= {pipe_q[STAGES-2:0], din[g]};
            end
        end

        assign dout[g] = pipe_q[STAGES-1];
    end

endmodule

// File: rtl/rsp_edge.sv
module rsp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl;
        end
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/rsp_rom.sv
module rsp_rom #(
    parameter int         DEPTH = 256,
    parameter logic [7:0] SEED  = 8'h5B,
    localparam int        AW    = $clog2(DEPTH)
) (
    input  logic [AW-1:0] idx,
    output logic [7:0]    rd_data
);

    function automatic logic [7:0] pattern(input int unsigned i);
        logic [31:0] v;
        v = i * 32'd29 + 32'(SEED);
        return v[7:0];
    endfunction

    logic [7:0] table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign table_w[g] = pattern(g);
    end

    assign rd_data = table_w[idx];

endmodule

// File: rtl/rsp_ctrl.sv
module rsp_ctrl
    import rsp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_hi,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          sdi_s,
    input  logic          busy,
    input  logic [7:0]    rom_data,
    output logic [AW-1:0] rom_idx,
    output logic          sdo,
    output logic          sdo_oe
);

    rsp_state_e           state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [ADDR_BITS-1:0] sr_q;
    logic [ADDR_BITS-1:0] addr_q;
    logic [ADDR_BITS-1:0] cap_addr;
    logic [ADDR_BITS-1:0] addr_inc;
    logic [7:0]           tx_q;
    logic [2:0]           txcnt_q;
    logic                 out_q;
    logic                 oe_q;
    logic                 opc_last;
    logic                 addr_last;
    logic                 opc_match;
    logic                 in_cmd;

    assign cap_addr  = {sr_q[ADDR_BITS-2:0], sdi_s};
    assign addr_inc  = addr_q + ADDR_BITS'(1);
    assign opc_last  = (cnt_q == CNT_W'(OPC_BITS - 1));
    assign addr_last = (cnt_q == CNT_W'(ADDR_BITS - 1));
    assign opc_match = (cap_addr[7:0] == RD_OPCODE);
    assign in_cmd    = (state_q == ST_OPCODE) || (state_q == ST_ADDR);

    // Array index: the captured address while it completes, else the next byte.
    assign rom_idx = (state_q == ST_ADDR) ? cap_addr[AW-1:0] : addr_inc[AW-1:0];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_hi) begin
            state_d = ST_IDLE;                       // DESELECT
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;      // SELECT
                ST_OPCODE: begin
                    if (sclk_rise && opc_last) begin
                        state_d = (opc_match && !busy) ? ST_ADDR : ST_IGNORE;
                    end
                end
                ST_ADDR: begin
                    if (sclk_rise && addr_last) begin
                        state_d = ST_DATA;           // STREAM
                    end
                end
                ST_DATA:   state_d = ST_DATA;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Command capture and transmit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sr_q    <= '0;
            addr_q  <= '0;
            tx_q    <= '0;
            txcnt_q <= '0;
        end else if (cs_hi || state_q == ST_IDLE) begin
            cnt_q   <= '0;
            txcnt_q <= '0;
        end else begin
            if (in_cmd && sclk_rise) begin
                sr_q <= cap_addr;
                if (state_q == ST_OPCODE && opc_last) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                if (state_q == ST_ADDR && addr_last) begin
                    addr_q  <= cap_addr;
                    tx_q    <= rom_data;
                    txcnt_q <= '0;
                end
            end
            if (state_q == ST_DATA && sclk_fall) begin
                if (txcnt_q == 3'd7) begin
                    addr_q  <= addr_inc;
                    tx_q    <= rom_data;
                    txcnt_q <= '0;
                end else begin
                    tx_q    <= {tx_q[6:0], 1'b0};
                    txcnt_q <= txcnt_q + 3'd1;
                end
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (cs_hi || state_q == ST_IDLE) begin
            oe_q  <= 1'b0;
        end else if (state_q == ST_DATA && sclk_fall) begin
            out_q <= tx_q[7];
            oe_q  <= 1'b1;
        end
    end

    assign sdo    = out_q;
    assign sdo_oe = oe_q;

    AST_OE_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (state_q == ST_DATA)); // R10

    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (!oe_q && state_q == ST_IDLE)); // R6

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPCODE && sclk_rise && opc_last && busy) |=> (state_q != ST_ADDR)); // R7

    AST_IGNORE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |=> ((state_q == ST_IGNORE || state_q == ST_IDLE) && !oe_q)); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_DATA && !$stable(addr_q)) |-> (addr_q == $past(addr_q) + ADDR_BITS'(1))); // R4

    AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> $past(sclk_fall)); // R3

endmodule

// File: rtl/spi_read_responder.sv
module spi_read_responder #(
    parameter int         DEPTH       = 256,
    parameter logic [7:0] SEED        = 8'h5B,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    input  logic busy,
    output logic sdo,
    output logic sdo_oe
);

    localparam int AW = $clog2(DEPTH);

    logic          cs_s;
    logic          sclk_s;
    logic          sdi_s;
    logic          sclk_rise;
    logic          sclk_fall;
    logic [AW-1:0] rom_idx;
    logic [7:0]    rom_data;

    rsp_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk, sdi}),
        .dout  ({cs_s, sclk_s, sdi_s})
    );

    rsp_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sclk_s),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    rsp_rom #(
        .DEPTH (DEPTH),
        .SEED  (SEED)
    ) u_rom (
        .idx     (rom_idx),
        .rd_data (rom_data)
    );

    rsp_ctrl #(
        .AW (AW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_hi     (cs_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s),
        .busy      (busy),
        .rom_data  (rom_data),
        .rom_idx   (rom_idx),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !sdo_oe); // R1

endmodule

// File: tb/spi_read_responder_tb.sv
module spi_read_responder_tb;

    localparam int         DEPTH = 64;
    localparam logic [7:0] SEED  = 8'h5B;
    localparam int         HALF  = 8;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n  = 1'b1;
    logic sclk  = 1'b0;
    logic sdi   = 1'b0;
    logic busy  = 1'b0;
    logic sdo;
    logic sdo_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    spi_read_responder #(
        .DEPTH (DEPTH),
        .SEED  (SEED)
    ) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .sdi    (sdi),
        .busy   (busy),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [23:0] a);
        int unsigned idx;
        logic [31:0] v;
        idx = a % DEPTH;
        v   = idx * 32'd29 + 32'(SEED);
        return v[7:0];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic d_rise, output logic d_late,
                           output logic oe_r, output logic oe_l);
        sdi = b;
        tick(HALF);
        d_rise = sdo;
        oe_r   = sdo_oe;
        sclk   = 1'b1;
        tick(HALF);
        d_late = sdo;
        oe_l   = sdo_oe;
        sclk   = 1'b0;
    endtask

    task automatic send_bits(input logic [23:0] v, input int n, output bit oe_any);
        logic dr, dl, orr, ol;
        oe_any = 1'b0;
        for (int i = n - 1; i >= 0; i--) begin
            clk_bit(v[i], dr, dl, orr, ol);
            oe_any = oe_any | orr | ol;
        end
    endtask

    task automatic recv_byte(output logic [7:0] d, output bit steady, output bit oe_all);
        logic dr, dl, orr, ol;
        steady = 1'b1;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b0, dr, dl, orr, ol);
            d[i]   = dr;
            steady = steady & (dr == dl);
            oe_all = oe_all & orr & ol;
        end
    endtask

    task automatic select_dev();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic deselect_dev();
        cs_n = 1'b1;
        tick(5);
        chk(sdo_oe == 1'b0, "R6", "oe after chip-select high", sdo_oe, 0);
        tick(HALF);
    endtask

    task automatic read_check(input logic [23:0] a, input int n, input string req);
        bit oe_cmd, oe_tmp, steady, oe_all;
        logic [7:0]  d;
        logic [23:0] ak;
        select_dev();
        send_bits(24'h000003, 8, oe_cmd);
        send_bits(a, 24, oe_tmp);
        oe_cmd = oe_cmd | oe_tmp;
        chk(!oe_cmd, "R10", "oe during command phase", oe_cmd, 0);
        for (int k = 0; k < n; k++) begin
            ak = a + 24'(k);
            recv_byte(d, steady, oe_all);
            chk(d == exp_byte(ak), req, "data byte", d, exp_byte(ak));
            chk(steady, "R3", "bit held through high phase", steady, 1);
            chk(oe_all, "R3", "oe during data phase", oe_all, 1);
        end
        deselect_dev();
    endtask

    initial begin : main
        bit          oe_seen, oe_tmp;
        logic        dr, dl, orr, ol;
        logic [31:0] r;
        int          n;
        void'($urandom(32'd13579));

        tick(4);
        chk(sdo_oe == 1'b0, "R1", "oe in reset", sdo_oe, 0);
        rst_n = 1'b1;
        tick(4);
        chk(sdo_oe == 1'b0, "R1", "oe after reset", sdo_oe, 0);

        // Clocks with chip-select high must not start anything
        send_bits(24'h0000C3, 8, oe_seen);
        chk(!oe_seen, "R1", "oe with chip-select high", oe_seen, 0);

        read_check(24'h000010, 3, "R2");
        read_check(24'h00002A, 6, "R4");
        read_check(24'hFFFFFE, 4, "R5");
        read_check(24'h00003E, 3, "R5");
        read_check(24'hABCD05, 2, "R9");
        read_check(24'h7FFFBF, 2, "R9");

        // R7: busy at the end of the read code blocks the whole transaction
        select_dev();
        busy = 1'b1;
        send_bits(24'h000003, 8, oe_seen);
        busy = 1'b0;
        send_bits(24'h000011, 24, oe_tmp);
        oe_seen = oe_seen | oe_tmp;
        send_bits(24'h00FFFF, 16, oe_tmp);
        oe_seen = oe_seen | oe_tmp;
        chk(!oe_seen, "R7", "oe while read dropped for busy", oe_seen, 0);
        deselect_dev();
        read_check(24'h000011, 1, "R7");

        // R8: unknown opcodes
        select_dev();
        send_bits(24'h00000B, 8, oe_seen);
        send_bits(24'h000003, 24, oe_tmp);
        oe_seen = oe_seen | oe_tmp;
        send_bits(24'h000000, 16, oe_tmp);
        oe_seen = oe_seen | oe_tmp;
        chk(!oe_seen, "R8", "oe after opcode 0x0B", oe_seen, 0);
        deselect_dev();
        select_dev();
        send_bits(24'h000083, 8, oe_seen);
        send_bits(24'h000000, 24, oe_tmp);
        oe_seen = oe_seen | oe_tmp;
        send_bits(24'h000000, 8, oe_tmp);
        oe_seen = oe_seen | oe_tmp;
        chk(!oe_seen, "R8", "oe after opcode 0x83", oe_seen, 0);
        deselect_dev();
        read_check(24'h000021, 2, "R8");

        // R6: abort mid data byte, mid address, mid opcode
        select_dev();
        send_bits(24'h000003, 8, oe_seen);
        send_bits(24'h000020, 24, oe_seen);
        for (int i = 0; i < 3; i++) clk_bit(1'b0, dr, dl, orr, ol);
        deselect_dev();
        read_check(24'h000007, 2, "R6");

        select_dev();
        send_bits(24'h000003, 8, oe_seen);
        send_bits(24'h0003FF, 10, oe_seen);
        deselect_dev();
        read_check(24'h000033, 2, "R6");

        select_dev();
        send_bits(24'h00001F, 5, oe_seen);
        deselect_dev();
        read_check(24'h00003F, 2, "R6");

        // Random reads
        for (int t = 0; t < 20; t++) begin
            r = $urandom;
            n = 1 + int'($urandom % 4);
            read_check(r[23:0], n, "R4");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule